// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

The block is a real-time clock core on a simple register bus. A programmable prescaler divides the reference clock into a once-per-second tick, and each tick advances a 32-bit seconds count. On every tick a sticky tick flag is set. When the new count equals the programmed alarm value and the alarm is armed, a sticky alarm flag is also set. Each flag has its own interrupt enable, and one level interrupt output combines the two. A 32-bit scratchpad register is included for software use. Every clock cycle of `clk` counts as one reference cycle. The latency of the slow-domain crossing is modelled as a fixed busy window after each accepted write.

No register takes a write until a write gate has been opened. Software first waits for the write-ready bit in the control register. It then writes the key value to the unlock register and waits until that register shows write-enabled. After waiting for write-ready once more, it performs exactly one data write, which closes the gate again. The gate is a four-state machine:

- `GS_LOCKED`: ready and closed.
- `GS_ARMING`: busy, opening.
- `GS_OPEN`: ready and open.
- `GS_DRAINING`: busy, closing.

It has four transitions:

- LOCKED to ARMING when the key is written.
- ARMING to OPEN when the busy window ends.
- OPEN to DRAINING on a data write.
- DRAINING to LOCKED when the busy window ends.

Reads are combinational on `bus_addr` and are never gated.

Top module: `rtc_core`

Register offsets are control 0x00, seconds 0x04, alarm 0x08, prescaler 0x0C, scratchpad 0x34 and unlock 0x3C. Unmapped offsets read as 0.

Control bits:

| Bit | Meaning | Access |
|-----|---------|--------|
| 0 | run | read/write |
| 2 | alarm armed | read/write |
| 3 | alarm interrupt enable | read/write |
| 4 | alarm flag | sticky |
| 5 | tick interrupt enable | read/write |
| 6 | tick flag | sticky |
| 7 | write-ready | read-only |

All other control bits read as 0.

## Requirements
- R1: After reset, the registers read as follows and `irq` is 0:

  | Register | Reset value |
  |----------|-------------|
  | control | 0x00000080 (only write-ready set) |
  | seconds | 0 |
  | alarm | 0 |
  | scratchpad | 0 |
  | unlock | 0 |
  | prescaler | PRESC_RST (default 0x7FFF) |
  | any unmapped offset | 0 |

- R2: A write of exactly 0x0000A55A to offset 0x3C while write-ready is 1 makes bit 31 of that register read 1 once the busy window has passed. A write of any other value there leaves it at 0.
- R3: A write to any register other than the unlock register has no effect unless the gate is open and write-ready is 1. This covers writes while locked and writes during a busy window.
- R4: After an accepted key write or data write, write-ready (control bit 7) reads 0 for exactly WR_LAT cycles, then reads 1 again. Bit 31 of the unlock register drops with the data write, so a second data write is ignored.
- R5: While run is 1, the seconds count increments once every (P+1) cycles, where P is the prescaler value. A write to the seconds register restarts that phase, so the first increment lands P+1 cycles after the write.
- R6: The seconds count wraps from 0xFFFFFFFF to 0.
- R7: Each tick sets the tick flag (control bit 6).
- R8: The alarm flag (control bit 4) sets on the tick where the seconds count becomes equal to the alarm register, only while alarm armed (bit 2) is 1.
- R9: In a control write, a 0 in a flag bit clears that flag and a 1 leaves it as it was. A tick or alarm match in the same cycle sets the flag regardless.
- R10: `irq` is 1 exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of the control register are both set.
- R11: The scratchpad at 0x34 reads back the last 32-bit value written through the gate.
- R12: While run is 0, the seconds count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one cycle per prescaler step |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The counter is driven with prescaler values of 0, 1, 3 and 6, and sampled after cycle counts that fall just before and exactly on an increment. This separates an off-by-one in the divide ratio from a wrong phase restart on a seconds write. Writes are presented in four conditions: locked, with a wrong key, inside the busy window, and after the single permitted data write. This tells a missing gate apart from a gate that never closes. The alarm is tried armed and unarmed, sampled one cycle before and on the matching tick. Flag writes carrying 1 and carrying 0 separate the keep-on-1 rule from a plain overwrite.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_ADDR_W = 8;
    localparam int REG_DATA_W = 32;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_SEC     = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_ALARM   = 8'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_PRESC   = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_SCRATCH = 8'h34;
    localparam logic [REG_ADDR_W-1:0] OFS_UNLOCK  = 8'h3C;

    localparam int B_RUN    = 0;
    localparam int B_ALME   = 2;
    localparam int B_ALMIE  = 3;
    localparam int B_ALMF   = 4;
    localparam int B_TICKIE = 5;
    localparam int B_TICKF  = 6;
    localparam int B_READY  = 7;
    localparam int B_WEN    = 31;

    localparam logic [REG_DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

    localparam int N_FLAGS = 2;
    localparam int FLAG_TICK  = 0;
    localparam int FLAG_ALARM = 1;

    typedef enum logic [1:0] {
        GS_LOCKED,
        GS_ARMING,
        GS_OPEN,
        GS_DRAINING
    } gate_state_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
    import rtc_pkg::*;
#(
    parameter int WR_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic to_unlock,
    input  logic key_ok,
    output logic wr_ready,
    output logic wr_open,
    output logic commit
);
    localparam int CNT_W = (WR_LAT < 2) ? 1 : $clog2(WR_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_LAT - 1);

    gate_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GS_LOCKED: begin
                if (req && to_unlock && key_ok) begin
                    state_d = GS_ARMING;
                    cnt_d   = CNT_LOAD;
                end
            end
            GS_ARMING: begin
                if (cnt_q == '0) state_d = GS_OPEN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            GS_OPEN: begin
                if (req && !to_unlock) begin
                    state_d = GS_DRAINING;
                    cnt_d   = CNT_LOAD;
                end
            end
            GS_DRAINING: begin
                if (cnt_q == '0) state_d = GS_LOCKED;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = GS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wr_ready = 1'b0;
        wr_open  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            GS_LOCKED:   wr_ready = 1'b1;
            GS_OPEN: begin
                wr_ready = 1'b1;
                wr_open  = 1'b1;
                commit   = req && !to_unlock;
            end
            GS_ARMING, GS_DRAINING: wr_ready = 1'b0;
            default: wr_ready = 1'b0;
        endcase
    end

    a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wr_ready);
    a_r4_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wr_open);
    a_r2_open_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_open) |-> $past(!wr_ready));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && !restart && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || restart || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic keep,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (wr)  q <= q & keep;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int                   WR_LAT    = 2,
    parameter logic [REG_DATA_W-1:0] PRESC_RST = 32'h0000_7FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    output logic                  irq
);
    localparam logic [REG_DATA_W-1:0] SEC_MAX = '1;

    logic req, wr_ready, wr_open, commit;
    logic wr_ctrl, wr_sec, wr_alarm, wr_presc, wr_scratch;
    logic tick, alarm_hit;
    logic run_q, alme_q, almie_q, tickie_q;
    logic [REG_DATA_W-1:0] sec_q, alarm_q, presc_q, scratch_q, sec_inc;
    logic [N_FLAGS-1:0] flag_q, flag_set, flag_keep;

    assign req = bus_sel && bus_wr;

    rtc_wr_gate #(.WR_LAT(WR_LAT)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .to_unlock(bus_addr == OFS_UNLOCK),
        .key_ok   (bus_wdata == UNLOCK_KEY),
        .wr_ready (wr_ready),
        .wr_open  (wr_open),
        .commit   (commit)
    );

    assign wr_ctrl    = commit && (bus_addr == OFS_CTRL);
    assign wr_sec     = commit && (bus_addr == OFS_SEC);
    assign wr_alarm   = commit && (bus_addr == OFS_ALARM);
    assign wr_presc   = commit && (bus_addr == OFS_PRESC);
    assign wr_scratch = commit && (bus_addr == OFS_SCRATCH);

    rtc_prescaler #(.CNT_W(REG_DATA_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .restart(wr_sec),
        .limit  (presc_q),
        .tick   (tick)
    );

    assign sec_inc   = sec_q + 1'b1;
    assign alarm_hit = tick && alme_q && (sec_inc == alarm_q);

    assign flag_set[FLAG_TICK]   = tick;
    assign flag_set[FLAG_ALARM]  = alarm_hit;
    assign flag_keep[FLAG_TICK]  = bus_wdata[B_TICKF];
    assign flag_keep[FLAG_ALARM] = bus_wdata[B_ALMF];

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        rtc_sticky_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (flag_set[g]),
            .wr   (wr_ctrl),
            .keep (flag_keep[g]),
            .q    (flag_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            alme_q    <= 1'b0;
            almie_q   <= 1'b0;
            tickie_q  <= 1'b0;
            sec_q     <= '0;
            alarm_q   <= '0;
            presc_q   <= PRESC_RST;
            scratch_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q    <= bus_wdata[B_RUN];
                alme_q   <= bus_wdata[B_ALME];
                almie_q  <= bus_wdata[B_ALMIE];
                tickie_q <= bus_wdata[B_TICKIE];
            end
            if (wr_sec)      sec_q <= bus_wdata;
            else if (tick)   sec_q <= sec_inc;
            if (wr_alarm)    alarm_q   <= bus_wdata;
            if (wr_presc)    presc_q   <= bus_wdata;
            if (wr_scratch)  scratch_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[B_RUN]    = run_q;
                bus_rdata[B_ALME]   = alme_q;
                bus_rdata[B_ALMIE]  = almie_q;
                bus_rdata[B_ALMF]   = flag_q[FLAG_ALARM];
                bus_rdata[B_TICKIE] = tickie_q;
                bus_rdata[B_TICKF]  = flag_q[FLAG_TICK];
                bus_rdata[B_READY]  = wr_ready;
            end
            OFS_SEC:     bus_rdata = sec_q;
            OFS_ALARM:   bus_rdata = alarm_q;
            OFS_PRESC:   bus_rdata = presc_q;
            OFS_SCRATCH: bus_rdata = scratch_q;
            OFS_UNLOCK:  bus_rdata[B_WEN] = wr_open;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (flag_q[FLAG_TICK] && tickie_q) || (flag_q[FLAG_ALARM] && almie_q);

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (sec_q == SEC_MAX) |=> (sec_q == '0));
    a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !wr_sec |=> $stable(sec_q));
    a_r7_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag_q[FLAG_TICK]);
    a_r8_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[FLAG_ALARM]) |-> $past(tick));
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (presc_q != '0) && !wr_presc |=> !tick);
    a_r10_quiet_without_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> !irq);
endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALM = 8'h08,
                           A_PRE = 8'h0C, A_SCR = 8'h34, A_UNL = 8'h3C;
    localparam logic [31:0] KEY = 32'h0000A55A;

    // prescaler, cycles after the seconds write, expected increments
    localparam logic [95:0] VEC [5] = '{
        {32'd0, 32'd5,  32'd5},
        {32'd1, 32'd5,  32'd2},
        {32'd3, 32'd7,  32'd1},
        {32'd3, 32'd8,  32'd2},
        {32'd6, 32'd20, 32'd2}
    };

    rtc_core u_rtc_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic raw_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #0.5;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wait_bit(input logic [7:0] a, input int b);
        logic [31:0] d;
        for (int i = 0; i < 100; i++) begin
            rd(a, d);
            if (d[b]) break;
            @(posedge clk); #0.5;
        end
    endtask

    task automatic full_write(input logic [7:0] a, input logic [31:0] d);
        wait_bit(A_CTRL, 7);
        raw_write(A_UNL, KEY);
        wait_bit(A_UNL, 31);
        wait_bit(A_CTRL, 7);
        raw_write(a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #0.5;

        // R1 reset state
        rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h80);
        rd(A_SEC, d);   chk("R1 seconds", d, 0);
        rd(A_ALM, d);   chk("R1 alarm", d, 0);
        rd(A_PRE, d);   chk("R1 prescaler", d, 32'h7FFF);
        rd(A_SCR, d);   chk("R1 scratch", d, 0);
        rd(A_UNL, d);   chk("R1 unlock", d, 0);
        rd(8'h10, d);   chk("R1 unmapped", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R3 locked write ignored
        raw_write(A_SCR, 32'h1111);
        rd(A_SCR, d);   chk("R3 locked write", d, 0);

        // R2 wrong key
        raw_write(A_UNL, 32'h1234);
        rd(A_UNL, d);   chk("R2 wrong key", d, 0);

        // R2/R4 key, then a write inside the busy window
        raw_write(A_UNL, KEY);
        raw_write(A_SCR, 32'h2222);
        rd(A_CTRL, d);  chk("R4 ready low while arming", {31'd0, d[7]}, 0);
        rd(A_UNL, d);   chk("R2 not yet open", d, 0);
        @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R4 ready back", {31'd0, d[7]}, 1);
        rd(A_UNL, d);   chk("R2 open", d, 32'h8000_0000);
        rd(A_SCR, d);   chk("R3 busy write ignored", d, 0);

        raw_write(A_SCR, 32'hCAFE);
        rd(A_SCR, d);   chk("R11 scratch write", d, 32'hCAFE);
        rd(A_UNL, d);   chk("R4 gate closes", d, 0);
        rd(A_CTRL, d);  chk("R4 ready low after data", {31'd0, d[7]}, 0);
        repeat (3) @(posedge clk); #0.5;
        raw_write(A_SCR, 32'hBEEF);
        rd(A_SCR, d);   chk("R4 second write ignored", d, 32'hCAFE);

        // R5 divide ratio and phase restart, table walk
        full_write(A_CTRL, 32'h01);
        for (int i = 0; i < 5; i++) begin
            full_write(A_PRE, VEC[i][95:64]);
            full_write(A_SEC, 32'd1000);
            repeat (VEC[i][63:32]) @(posedge clk);
            #0.5;
            rd(A_SEC, d);
            chk($sformatf("R5 vector %0d", i), d, 32'd1000 + VEC[i][31:0]);
        end

        // R6 wrap
        full_write(A_PRE, 32'd3);
        full_write(A_SEC, 32'hFFFF_FFFF);
        repeat (3) @(posedge clk); #0.5;
        rd(A_SEC, d);   chk("R6 before wrap", d, 32'hFFFF_FFFF);
        @(posedge clk); #0.5;
        rd(A_SEC, d);   chk("R6 wrapped", d, 0);

        // R7 tick flag, R10 masked
        rd(A_CTRL, d);  chk("R7 tick flag set", {31'd0, d[6]}, 1);
        chk("R10 masked irq", {31'd0, irq}, 0);

        // R9 keep on 1, R12 stop
        full_write(A_CTRL, 32'h50);
        repeat (WR_WAIT) @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R9 flag kept", d & 32'h7F, 32'h40);
        rd(A_SEC, d);
        repeat (12) @(posedge clk); #0.5;
        begin
            logic [31:0] d2;
            rd(A_SEC, d2); chk("R12 frozen", d2, d);
        end
        full_write(A_CTRL, 32'h60);
        repeat (WR_WAIT) @(posedge clk); #0.5;
        chk("R10 tick irq", {31'd0, irq}, 1);
        full_write(A_CTRL, 32'h20);
        repeat (WR_WAIT) @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R9 flag cleared", {31'd0, d[6]}, 0);
        chk("R10 irq after clear", {31'd0, irq}, 0);

        // R8 armed alarm
        full_write(A_ALM, 32'd500);
        full_write(A_CTRL, 32'h0D);
        full_write(A_SEC, 32'd498);
        repeat (7) @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R8 alarm not yet", {31'd0, d[4]}, 0);
        @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R8 alarm flag", {31'd0, d[4]}, 1);
        chk("R10 alarm irq", {31'd0, irq}, 1);
        full_write(A_CTRL, 32'h4D);
        repeat (WR_WAIT) @(posedge clk); #0.5;
        rd(A_CTRL, d);  chk("R9 alarm cleared", {31'd0, d[4]}, 0);
        chk("R10 irq off", {31'd0, irq}, 0);

        // R8 unarmed alarm
        full_write(A_ALM, 32'd600);
        full_write(A_CTRL, 32'h09);
        full_write(A_SEC, 32'd598);
        repeat (9) @(posedge clk); #0.5;
        rd(A_SEC, d);   chk("R8 count passed match", d, 32'd600);
        rd(A_CTRL, d);  chk("R8 unarmed no flag", {31'd0, d[4]}, 0);
        chk("R8 unarmed no irq", {31'd0, irq}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam int WR_WAIT = 4;
endmodule